// File: doc/BRIEF.md
# Dual-Lane Shared Multiply/Multiply-Accumulate Unit

This block is the arithmetic stage of a 64-bit vector datapath. It treats each source word as two 32-bit lanes. Each lane multiplies the low 16 bits of the lane from the two sources, unsigned. The upper 16 bits of every lane are not used. Two operations share one datapath. The multiply operation returns the two 32-bit products side by side. The multiply-accumulate operation adds each product to the matching 32-bit half of a destination word.

Both operations go through the same pair of multiply-add elements. For a plain multiply the addend is forced to zero, so the design has only two multipliers. Operands enter through a valid/ready stream. The result leaves from a single output register through a second valid/ready stream.

Both streams obey the usual rules. A transfer happens on a rising clock edge when valid and ready are both high. The producer holds its data steady while valid is high and ready is low. The block asserts `in_ready` whenever its output register is empty or is being emptied in the same cycle. While the consumer stalls, the result and `out_valid` stay unchanged and no new operand is taken.

Top module: `dual_lane_mac`

## Requirements
- R1: Lane 0 computes `src_s[15:0] * src_t[15:0]` and returns it on `out_result[31:0]`.
- R2: Lane 1 computes `src_s[47:32] * src_t[47:32]` and returns it on `out_result[63:32]`.
- R3: Bits [31:16] and [63:48] of both sources have no effect on the result.
- R4: With `in_op` = 1 (multiply-accumulate), each lane adds its product to the matching 32-bit half of `dst_in`. With `in_op` = 0 (multiply), the addend is zero and `dst_in` has no effect.
- R5: The multiplication is unsigned: 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R6: Each lane sum wraps modulo 2^32, and no carry passes from lane 0 into lane 1.
- R7: The result of an accepted operand set appears on `out_result`, with `out_valid` high, on the clock edge that accepts it. It is therefore visible one cycle after the input was presented.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` stay unchanged.
- R9: When no operand is accepted, `out_result` keeps its previous value. `out_valid` drops after the result is taken.
- R10: After reset, `out_valid` is low and `out_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block can take an operand set |
| in_op | input | 1 | 0 = dual multiply, 1 = dual multiply-accumulate |
| src_s | input | 64 | First source word |
| src_t | input | 64 | Second source word |
| dst_in | input | 64 | Current destination value (addend for multiply-accumulate) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Registered result, lane 1 in the upper half |

## Verification
Small operands placed in only one lane show that each product reaches its own half and nowhere else. Filling the unused upper bits of each lane with garbage shows that those bits are ignored. Full-scale 0xFFFF operands distinguish an unsigned product from a signed one. The same operands are also sent with a large addend, which shows that lane 0 wraps and that its carry does not leak into lane 1. Running the same operands as multiply and as multiply-accumulate with a nonzero destination shows that the addend is zeroed only for multiply. A long random stream with random input valid and output ready is compared against a behavioural model on every clock. This exercises stalls, back-to-back transfers and idle holds.

// File: rtl/dlmac_pkg.sv
package dlmac_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAC = 1'b1
  } dlmac_op_e;
endpackage

// File: rtl/dlmac_lane.sv
// One shared multiply-add element: product plus a selectable addend.
module dlmac_lane #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic [IN_W-1:0]  mul_a,
  input  logic [IN_W-1:0]  mul_b,
  input  logic             add_en,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] sum_out
);
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] product;

  // Zeroing the addend turns the multiply-add element into a plain multiplier.
  always_comb begin
    addend  = add_en ? acc_in : '0;
    product = ACC_W'(mul_a) * ACC_W'(mul_b);
    sum_out = product + addend;
  end
endmodule

// File: rtl/dlmac_ostage.sv
// Output register with valid/ready handshake on both sides.
module dlmac_ostage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic fire;

  always_comb begin
    in_ready = !out_valid || out_ready;
    fire     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled result stays put
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: accepted input yields valid output on the next cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: no acceptance, no change in data
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));

  // R9: a taken result with no new input clears valid
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/dual_lane_mac.sv
module dual_lane_mac #(
  parameter int LANES  = 2,
  parameter int LANE_W = 32,
  parameter int IN_W   = 16,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  input  logic [DATA_W-1:0] dst_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  import dlmac_pkg::*;

  dlmac_op_e        op_sel;
  logic             use_acc;
  logic [DATA_W-1:0] lane_sums;

  always_comb begin
    op_sel  = dlmac_op_e'(in_op);
    use_acc = (op_sel == OP_MAC);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dlmac_lane #(.IN_W(IN_W), .ACC_W(LANE_W)) u_lane (
      .mul_a  (src_s[g*LANE_W +: IN_W]),
      .mul_b  (src_t[g*LANE_W +: IN_W]),
      .add_en (use_acc),
      .acc_in (dst_in[g*LANE_W +: LANE_W]),
      .sum_out(lane_sums[g*LANE_W +: LANE_W])
    );

    // R1 R2: each lane's multiply lands in its own half, one cycle later
    a_r1_r2_lane_mul: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_op) |=>
        (out_result[g*LANE_W +: LANE_W] ==
         LANE_W'($past(src_s[g*LANE_W +: IN_W])) * LANE_W'($past(src_t[g*LANE_W +: IN_W]))));

    // R4: multiply-accumulate adds the destination half
    a_r4_lane_mac: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op) |=>
        (out_result[g*LANE_W +: LANE_W] ==
         LANE_W'($past(src_s[g*LANE_W +: IN_W])) * LANE_W'($past(src_t[g*LANE_W +: IN_W]))
         + $past(dst_in[g*LANE_W +: LANE_W])));
  end

  dlmac_ostage #(.W(DATA_W)) u_ostage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (lane_sums),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_result)
  );
endmodule

// File: tb/dual_lane_mac_bench.sv
`timescale 1ns/1ps
module dual_lane_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [63:0] src_s = '0, src_t = '0, dst_in = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_lane_mac u_dual_lane_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .src_s(src_s), .src_t(src_t), .dst_in(dst_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [63:0] model_calc(logic op, logic [63:0] s, logic [63:0] t,
                                             logic [63:0] d);
    longint unsigned p0, p1, a0, a1;
    p0 = longint'(s[15:0]) * longint'(t[15:0]);
    p1 = longint'(s[47:32]) * longint'(t[47:32]);
    a0 = op ? longint'(d[31:0]) : 0;
    a1 = op ? longint'(d[63:32]) : 0;
    p0 = (p0 + a0) % 64'h1_0000_0000;
    p1 = (p1 + a1) % 64'h1_0000_0000;
    return {p1[31:0], p0[31:0]};
  endfunction

  // Behavioural reference model of the output stream
  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
      exp_r <= '0;
    end else if (in_valid && (!exp_v || out_ready)) begin
      exp_v <= 1'b1;
      exp_r <= model_calc(in_op, src_s, src_t, dst_in);
    end else if (out_ready) begin
      exp_v <= 1'b0;
    end
  end

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check64("R7 R9 model out_valid", {63'b0, out_valid}, {63'b0, exp_v});
      check64("R7 R9 model out_result", out_result, exp_r);
      check64("R8 model in_ready", {63'b0, in_ready}, {63'b0, (!exp_v || out_ready)});
    end
  end

  task automatic run_one(string tag, logic op, logic [63:0] s, logic [63:0] t,
                         logic [63:0] d, logic [63:0] exp);
    in_valid = 1'b1; in_op = op; src_s = s; src_t = t; dst_in = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64({tag, " valid"}, {63'b0, out_valid}, 64'd1);
    check64(tag, out_result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R10 reset out_valid", {63'b0, out_valid}, 64'd0);
    check64("R10 reset out_result", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one("R1 lane0 mul", 1'b0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005,
            64'h0, 64'h0000_0000_0000_000F);
    run_one("R2 lane1 mul", 1'b0, 64'h0000_0007_0000_0000, 64'h0000_0009_0000_0000,
            64'h0, 64'h0000_003F_0000_0000);
    run_one("R3 upper bits ignored", 1'b0, 64'hFFFF_0002_FFFF_0004, 64'hABCD_0003_1234_0005,
            64'h0, 64'h0000_0006_0000_0014);
    run_one("R5 unsigned", 1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_FFFF,
            64'h0, 64'hFFFE_0001_FFFE_0001);
    run_one("R4 mac adds dst", 1'b1, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005,
            64'h0000_0100_0000_1000, 64'h0000_0108_0000_100F);
    run_one("R4 mul ignores dst", 1'b0, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005,
            64'h0000_0100_0000_1000, 64'h0000_0008_0000_000F);
    run_one("R6 wrap no carry", 1'b1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF,
            64'h0000_0005_0001_FFFF, 64'h0000_0005_0000_0000);

    // R9: idle cycle, result held and valid drops
    @(negedge clk);
    check64("R9 idle hold", out_result, 64'h0000_0005_0000_0000);
    check64("R9 valid drops", {63'b0, out_valid}, 64'd0);

    // R8: stall with a new input waiting
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 1'b0; src_s = 64'h0000_0001_0000_0002; src_t = 64'h0000_0003_0000_0004;
    @(negedge clk);
    check64("R8 first accepted", out_result, 64'h0000_0003_0000_0008);
    src_s = 64'h0000_0009_0000_0009; src_t = 64'h0000_0009_0000_0009;
    repeat (3) @(negedge clk);
    check64("R8 stall holds result", out_result, 64'h0000_0003_0000_0008);
    check64("R8 stall ready low", {63'b0, in_ready}, 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R8 second after release", out_result, 64'h0000_0051_0000_0051);

    // Random stream against the model
    for (int i = 0; i < 400; i++) begin
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      if (!(in_valid && !in_ready)) begin
        in_op  = $urandom % 2;
        src_s  = {$urandom, $urandom};
        src_t  = {$urandom, $urandom};
        dst_in = {$urandom, $urandom};
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule